// File: doc/BRIEF.md
# SMBus host controller register front-end

This block is the processor-facing side of an SMBus host controller. Software programs a small byte-wide register bank: a command byte, a slave address whose low bit picks the transfer direction, two data bytes, and a 32-entry block buffer that it reaches through one auto-incrementing port. Writing the control register with the start bit set launches a transaction of the kind named by the control protocol field.

The sequencer checks the protocol code. For a supported code it raises a request to a bus engine outside this block. The request carries the protocol, direction, 7-bit address, command and data bytes. The request is held until the engine answers with a one-cycle response. Read responses are then stored into the data registers. During a block transfer the engine reaches the block buffer through a separate index/data port. An unsupported code launches nothing and raises a failure flag in the status register. While a request is pending the controller reports busy and drops register writes, except writes to the status register.

Top module: `smb_host_regs`

## Requirements
- R1: Offsets 3 (command), 4 (address), 5 (data0) and 6 (data1) read back the last byte written to them. Offset 1 always reads 0. After reset every register, the status register and every buffer entry read 0.
- R2: A control write (offset 2) with bit 6 set, made while idle, raises reqValid on the next cycle. It presents reqProto = control bits 4:2, reqRead = address bit 0, reqAddr = address bits 7:1, reqCmd = command, and reqData0/reqData1 = data0/data1. A send-byte request (code 1, write) carries its data in reqCmd.
- R3: A start with protocol code 4, 6 or 7 issues no request and sets status bit 2. Supported codes are 0 quick, 1 send/receive byte, 2 byte data, 3 word data and 5 block.
- R4: Any write to status (offset 0) clears status bit 2 and rewinds the block index to entry 0, busy or not.
- R5: A control read returns control bits 4:0 in bits 4:0 with bits 7:5 zero, so the start bit never reads back. It also rewinds the block index to 0.
- R6: Each read or write of offset 7 accesses the buffer entry at the block index and then advances the index. The index wraps from 31 to 0.
- R7: When a read transaction's response arrives, codes 1 and 2 load data0 from rspData0. Code 3 loads data0 from rspData0 and data1 from rspData1. Code 5 loads data0 with the byte count in rspData0.
- R8: A write transaction's response leaves data0 and data1 unchanged.
- R9: From the start until the cycle after rspValid, reqValid stays high with its fields stable, and status bit 0 reads 1. Writes to offsets 2 to 7 are ignored during that time, including a second start.
- R10: engBufRdData shows the buffer entry at engBufIdx in the same cycle. While busy, engBufWe writes engBufWrData into that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects at the clock edge) |
| regAddr | input | 3 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| reqValid | output | 1 | Request to bus engine pending (busy) |
| reqProto | output | 3 | Protocol code |
| reqRead | output | 1 | 1 = read, 0 = write |
| reqAddr | output | 7 | 7-bit slave address |
| reqCmd | output | 8 | Command byte |
| reqData0 | output | 8 | Data byte 0 / block count |
| reqData1 | output | 8 | Data byte 1 |
| rspValid | input | 1 | One-cycle response from bus engine |
| rspData0 | input | 8 | Returned low byte or block count |
| rspData1 | input | 8 | Returned high byte |
| engBufIdx | input | 5 | Engine buffer index |
| engBufWe | input | 1 | Engine buffer write enable |
| engBufWrData | input | 8 | Engine buffer write data |
| engBufRdData | output | 8 | Buffer entry at engBufIdx |

## Verification
Register reads are combinational. The bench drives a read at a falling edge and samples regRdData two time units later, before the rising edge that applies the index side effect. A start write taken at one rising edge has reqValid and its fields visible at the following falling edge. A response given at one falling edge is captured at the next rising edge, so the data registers and the cleared busy flag are checked from the falling edge after that. Every expected read value is pushed into a queue by the driver and popped by the monitor at its sample point. The checks of the "ignored" writes are reads made after busy ends.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_STAT = 3'd0;
  localparam logic [2:0] OFF_CTL  = 3'd2;
  localparam logic [2:0] OFF_CMD  = 3'd3;
  localparam logic [2:0] OFF_ADDR = 3'd4;
  localparam logic [2:0] OFF_D0   = 3'd5;
  localparam logic [2:0] OFF_D1   = 3'd6;
  localparam logic [2:0] OFF_BLK  = 3'd7;

  localparam int START_BIT = 6;

  typedef enum logic [2:0] {
    PROTO_QUICK = 3'd0,
    PROTO_BYTE  = 3'd1,
    PROTO_BDATA = 3'd2,
    PROTO_WORD  = 3'd3,
    PROTO_BLOCK = 3'd5
  } proto_e;

  typedef struct packed {
    logic launch;
    logic setFail;
    logic capture;
  } seqStrobes_t;

  function automatic logic protoSupported(input logic [2:0] code);
    return (code == PROTO_QUICK) || (code == PROTO_BYTE) ||
           (code == PROTO_BDATA) || (code == PROTO_WORD) ||
           (code == PROTO_BLOCK);
  endfunction
endpackage

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic [2:0]  startProto,
  input  logic        rspValid,
  output seqStrobes_t strb,
  output logic        busy
);
  typedef enum logic {SEQ_IDLE, SEQ_WAIT} seqState_e;
  seqState_e state;
  logic idle;

  assign idle = (state == SEQ_IDLE);
  assign busy = (state == SEQ_WAIT);

  always_comb begin
    strb.launch  = startReq && idle && protoSupported(startProto);
    strb.setFail = startReq && idle && !protoSupported(startProto);
    strb.capture = (state == SEQ_WAIT) && rspValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
    end else begin
      case (state)
        SEQ_IDLE: if (strb.launch) state <= SEQ_WAIT;
        SEQ_WAIT: if (rspValid) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_host_dp.sv
module smb_host_dp
  import smb_host_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  seqStrobes_t       strb,
  input  logic              busy,
  output logic              startReq,
  output logic [2:0]        startProto,
  output logic [2:0]        reqProto,
  output logic              reqRead,
  output logic [6:0]        reqAddr,
  output logic [BYTE_W-1:0] reqCmd,
  output logic [BYTE_W-1:0] reqData0,
  output logic [BYTE_W-1:0] reqData1,
  input  logic [BYTE_W-1:0] rspData0,
  input  logic [BYTE_W-1:0] rspData1,
  input  logic [IDX_W-1:0]  engBufIdx,
  input  logic              engBufWe,
  input  logic [BYTE_W-1:0] engBufWrData,
  output logic [BYTE_W-1:0] engBufRdData
);
  logic [4:0]        ctlReg;
  logic [BYTE_W-1:0] cmdReg, addrReg, d0Reg, d1Reg;
  logic              failFlag;
  logic [IDX_W-1:0]  blkIdx;
  logic [BYTE_W-1:0] bufMem [BUF_DEPTH];

  logic wrOk, statWr, cpuBlkWr, blkRd, rewind, advance;

  assign wrOk     = regWrEn && !busy;
  assign statWr   = regWrEn && (regAddr == OFF_STAT);
  assign cpuBlkWr = wrOk && (regAddr == OFF_BLK);
  assign blkRd    = regRdEn && (regAddr == OFF_BLK);
  assign rewind   = statWr || (regRdEn && (regAddr == OFF_CTL));
  assign advance  = blkRd || cpuBlkWr;

  assign startReq   = regWrEn && (regAddr == OFF_CTL) && regWrData[START_BIT];
  assign startProto = regWrData[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blkIdx <= '0;
    end else if (rewind) begin
      blkIdx <= '0;
    end else if (advance) begin
      blkIdx <= (blkIdx == IDX_W'(BUF_DEPTH - 1)) ? '0 : blkIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failFlag <= 1'b0;
    end else if (statWr) begin
      failFlag <= 1'b0;
    end else if (strb.setFail) begin
      failFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlReg  <= '0;
      cmdReg  <= '0;
      addrReg <= '0;
      d0Reg   <= '0;
      d1Reg   <= '0;
    end else if (wrOk) begin
      case (regAddr)
        OFF_CTL:  ctlReg  <= regWrData[4:0];
        OFF_CMD:  cmdReg  <= regWrData;
        OFF_ADDR: addrReg <= regWrData;
        OFF_D0:   d0Reg   <= regWrData;
        OFF_D1:   d1Reg   <= regWrData;
        default:  ;
      endcase
    end else if (strb.capture && addrReg[0]) begin
      case (ctlReg[4:2])
        PROTO_BYTE, PROTO_BDATA, PROTO_BLOCK: d0Reg <= rspData0;
        PROTO_WORD: begin
          d0Reg <= rspData0;
          d1Reg <= rspData1;
        end
        default: ;
      endcase
    end
  end

  for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bufMem[e] <= '0;
      end else if (cpuBlkWr && (blkIdx == IDX_W'(e))) begin
        bufMem[e] <= regWrData;
      end else if (busy && engBufWe && (engBufIdx == IDX_W'(e))) begin
        bufMem[e] <= engBufWrData;
      end
    end
  end

  assign engBufRdData = bufMem[engBufIdx];

  always_comb begin
    case (regAddr)
      OFF_STAT: regRdData = {5'd0, failFlag, 1'b0, busy};
      OFF_CTL:  regRdData = {3'd0, ctlReg};
      OFF_CMD:  regRdData = cmdReg;
      OFF_ADDR: regRdData = addrReg;
      OFF_D0:   regRdData = d0Reg;
      OFF_D1:   regRdData = d1Reg;
      OFF_BLK:  regRdData = bufMem[blkIdx];
      default:  regRdData = '0;
    endcase
  end

  assign reqProto = ctlReg[4:2];
  assign reqRead  = addrReg[0];
  assign reqAddr  = addrReg[7:1];
  assign reqCmd   = cmdReg;
  assign reqData0 = d0Reg;
  assign reqData1 = d1Reg;
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int BUF_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         regWrEn,
  input  logic                         regRdEn,
  input  logic [2:0]                   regAddr,
  input  logic [7:0]                   regWrData,
  output logic [7:0]                   regRdData,
  output logic                         reqValid,
  output logic [2:0]                   reqProto,
  output logic                         reqRead,
  output logic [6:0]                   reqAddr,
  output logic [7:0]                   reqCmd,
  output logic [7:0]                   reqData0,
  output logic [7:0]                   reqData1,
  input  logic                         rspValid,
  input  logic [7:0]                   rspData0,
  input  logic [7:0]                   rspData1,
  input  logic [$clog2(BUF_DEPTH)-1:0] engBufIdx,
  input  logic                         engBufWe,
  input  logic [7:0]                   engBufWrData,
  output logic [7:0]                   engBufRdData
);
  seqStrobes_t strb;
  logic        busy;
  logic        startReq;
  logic [2:0]  startProto;

  smb_host_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .startProto (startProto),
    .rspValid   (rspValid),
    .strb       (strb),
    .busy       (busy)
  );

  smb_host_dp #(.BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .strb         (strb),
    .busy         (busy),
    .startReq     (startReq),
    .startProto   (startProto),
    .reqProto     (reqProto),
    .reqRead      (reqRead),
    .reqAddr      (reqAddr),
    .reqCmd       (reqCmd),
    .reqData0     (reqData0),
    .reqData1     (reqData1),
    .rspData0     (rspData0),
    .rspData1     (rspData1),
    .engBufIdx    (engBufIdx),
    .engBufWe     (engBufWe),
    .engBufWrData (engBufWrData),
    .engBufRdData (engBufRdData)
  );

  assign reqValid = busy;
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk
  import smb_host_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       reqValid,
  input logic [2:0] reqProto,
  input logic       reqRead,
  input logic [6:0] reqAddr,
  input logic [7:0] reqCmd,
  input logic       rspValid
);
  logic startIdle;
  assign startIdle = regWrEn && (regAddr == OFF_CTL) && regWrData[START_BIT] && !reqValid;

  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (startIdle && protoSupported(regWrData[4:2])) |=> (reqValid && (reqProto == $past(regWrData[4:2]))));

  p_bad_proto_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (startIdle && !protoSupported(regWrData[4:2])) |=> !reqValid);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !rspValid) |=> (reqValid && $stable(reqProto) && $stable(reqRead) &&
                                 $stable(reqAddr) && $stable(reqCmd)));

  p_rsp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && rspValid) |=> !reqValid);

  p_ctl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && (regAddr == OFF_CTL)) |-> (regRdData[7:5] == 3'd0));

  p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && (regAddr == OFF_STAT)) |-> (regRdData[0] == reqValid));
endmodule

bind smb_host_regs smb_host_chk u_chk (.*);

// File: tb/smb_host_regs_bench.sv
module smb_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic       reqValid, reqRead;
  logic [2:0] reqProto;
  logic [6:0] reqAddr;
  logic [7:0] reqCmd, reqData0, reqData1;
  logic       rspValid = 1'b0;
  logic [7:0] rspData0 = '0, rspData1 = '0;
  logic [4:0] engBufIdx = '0;
  logic       engBufWe = 1'b0;
  logic [7:0] engBufWrData = '0, engBufRdData;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs u_smb_host_regs (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (regRdEn) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "scoreboard-empty", regRdData, 0);
      end else begin
        sbItem_t it;
        it = sbQ.pop_front();
        chk(regRdData === it.exp, it.tag, regRdData, it.exp);
      end
    end
  end

  task automatic cpuWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [2:0] a, input logic [7:0] exp, input string tag);
    sbItem_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    sbQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectReq(input logic [2:0] p, input logic rd, input logic [6:0] sa,
                           input logic [7:0] c, input logic [7:0] x0, input logic [7:0] x1,
                           input string tag);
    @(negedge clk); #1;
    chk(reqValid === 1'b1, tag, reqValid, 1);
    chk({reqProto, reqRead, reqAddr} === {p, rd, sa}, tag, {reqProto, reqRead, reqAddr}, {p, rd, sa});
    chk({reqCmd, reqData0, reqData1} === {c, x0, x1}, tag, {reqCmd, reqData0, reqData1}, {c, x0, x1});
  endtask

  task automatic respond(input logic [7:0] r0, input logic [7:0] r1);
    @(negedge clk);
    rspValid = 1'b1; rspData0 = r0; rspData1 = r1;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic expectNoReq(input string tag);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(reqValid === 1'b0, tag, reqValid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cpuRead(3'd0, 8'h00, "R1 reset status");
    cpuRead(3'd2, 8'h00, "R1 reset control");
    cpuRead(3'd3, 8'h00, "R1 reset command");
    cpuRead(3'd4, 8'h00, "R1 reset address");
    cpuRead(3'd5, 8'h00, "R1 reset data0");
    cpuRead(3'd6, 8'h00, "R1 reset data1");
    cpuRead(3'd7, 8'h00, "R1 reset buffer");
    @(negedge clk); #1;
    chk(reqValid === 1'b0, "R1 reset idle", reqValid, 0);

    // R1 readback
    cpuWrite(3'd3, 8'hA5); cpuWrite(3'd4, 8'h5B);
    cpuWrite(3'd5, 8'h11); cpuWrite(3'd6, 8'h22);
    cpuRead(3'd3, 8'hA5, "R1 command");
    cpuRead(3'd4, 8'h5B, "R1 address");
    cpuRead(3'd5, 8'h11, "R1 data0");
    cpuRead(3'd6, 8'h22, "R1 data1");
    cpuRead(3'd1, 8'h00, "R1 offset1");

    // R5 control mask
    cpuWrite(3'd2, 8'hBF);
    cpuRead(3'd2, 8'h1F, "R5 control mask");
    cpuWrite(3'd2, 8'h00);

    // R6 fill with wrap
    cpuWrite(3'd0, 8'h00);
    for (int i = 0; i < 34; i++) cpuWrite(3'd7, 8'(8'h40 + i));
    cpuRead(3'd2, 8'h00, "R5 rewind via control");
    for (int i = 0; i < 32; i++)
      cpuRead(3'd7, (i < 2) ? 8'(8'h60 + i) : 8'(8'h40 + i), "R6 buffer entry");
    cpuRead(3'd7, 8'h60, "R6 wrap to entry 0");
    cpuRead(3'd2, 8'h00, "R5 control read");
    cpuRead(3'd7, 8'h60, "R5 index rewound");
    cpuRead(3'd7, 8'h61, "R6 advance");
    cpuWrite(3'd0, 8'hFF);
    cpuRead(3'd7, 8'h60, "R4 index rewound");

    // word write, busy behaviour
    cpuWrite(3'd4, 8'hA0); cpuWrite(3'd3, 8'h33);
    cpuWrite(3'd5, 8'h44); cpuWrite(3'd6, 8'h55);
    cpuWrite(3'd2, 8'h4C);
    expectReq(3'd3, 1'b0, 7'h50, 8'h33, 8'h44, 8'h55, "R2 word write request");
    cpuRead(3'd0, 8'h01, "R9 busy flag");
    cpuWrite(3'd3, 8'h99);
    cpuWrite(3'd5, 8'h00);
    cpuWrite(3'd2, 8'h40);
    cpuRead(3'd3, 8'h33, "R9 command write ignored");
    cpuRead(3'd2, 8'h0C, "R9 restart ignored");
    expectReq(3'd3, 1'b0, 7'h50, 8'h33, 8'h44, 8'h55, "R9 request held");
    respond(8'hEE, 8'hFF);
    cpuRead(3'd0, 8'h00, "R9 busy cleared");
    cpuRead(3'd5, 8'h44, "R8 data0 kept");
    cpuRead(3'd6, 8'h55, "R8 data1 kept");

    // R7 word read
    cpuWrite(3'd4, 8'hA1);
    cpuWrite(3'd2, 8'h4C);
    expectReq(3'd3, 1'b1, 7'h50, 8'h33, 8'h44, 8'h55, "R2 word read request");
    respond(8'hEE, 8'hFF);
    cpuRead(3'd5, 8'hEE, "R7 word low");
    cpuRead(3'd6, 8'hFF, "R7 word high");

    // R7 byte data read
    cpuWrite(3'd2, 8'h48);
    expectReq(3'd2, 1'b1, 7'h50, 8'h33, 8'hEE, 8'hFF, "R2 byte data request");
    respond(8'h77, 8'h00);
    cpuRead(3'd5, 8'h77, "R7 byte data");
    cpuRead(3'd6, 8'hFF, "R7 data1 untouched");

    // R7 receive byte
    cpuWrite(3'd2, 8'h44);
    expectReq(3'd1, 1'b1, 7'h50, 8'h33, 8'h77, 8'hFF, "R2 receive request");
    respond(8'h12, 8'h34);
    cpuRead(3'd5, 8'h12, "R7 receive byte");

    // R2 send byte uses command
    cpuWrite(3'd4, 8'hA0); cpuWrite(3'd3, 8'h5A);
    cpuWrite(3'd2, 8'h44);
    expectReq(3'd1, 1'b0, 7'h50, 8'h5A, 8'h12, 8'hFF, "R2 send byte request");
    respond(8'h00, 8'h00);
    cpuRead(3'd5, 8'h12, "R8 send leaves data0");

    // R3 unsupported codes
    cpuWrite(3'd2, 8'h58);
    expectNoReq("R3 code 6 no request");
    cpuRead(3'd0, 8'h04, "R3 code 6 fail");
    cpuWrite(3'd0, 8'h00);
    cpuRead(3'd0, 8'h00, "R4 fail cleared");
    cpuWrite(3'd2, 8'h5C);
    expectNoReq("R3 code 7 no request");
    cpuRead(3'd0, 8'h04, "R3 code 7 fail");
    cpuWrite(3'd0, 8'h00);
    cpuWrite(3'd2, 8'h50);
    expectNoReq("R3 code 4 no request");
    cpuRead(3'd0, 8'h04, "R3 code 4 fail");

    // quick command with status write while busy
    cpuWrite(3'd2, 8'h40);
    expectReq(3'd0, 1'b0, 7'h50, 8'h5A, 8'h12, 8'hFF, "R2 quick request");
    cpuRead(3'd0, 8'h05, "R9 busy with fail");
    cpuWrite(3'd0, 8'h00);
    cpuRead(3'd0, 8'h01, "R4 status write while busy");
    respond(8'h00, 8'h00);
    cpuRead(3'd0, 8'h00, "R9 quick done");

    // block write, engine reads buffer
    cpuWrite(3'd0, 8'h00);
    cpuWrite(3'd7, 8'hC0); cpuWrite(3'd7, 8'hC1); cpuWrite(3'd7, 8'hC2);
    cpuWrite(3'd5, 8'h03); cpuWrite(3'd3, 8'h21);
    cpuWrite(3'd2, 8'h54);
    expectReq(3'd5, 1'b0, 7'h50, 8'h21, 8'h03, 8'hFF, "R2 block write request");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      engBufIdx = 5'(i);
      #1;
      chk(engBufRdData === 8'(8'hC0 + i), "R10 engine buffer read", engBufRdData, 8'(8'hC0 + i));
    end
    respond(8'h00, 8'h00);
    cpuRead(3'd5, 8'h03, "R8 block write count kept");

    // block read, engine fills buffer
    cpuWrite(3'd4, 8'hA1);
    cpuWrite(3'd2, 8'h54);
    expectReq(3'd5, 1'b1, 7'h50, 8'h21, 8'h03, 8'hFF, "R2 block read request");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      engBufWe = 1'b1; engBufIdx = 5'(i); engBufWrData = 8'(8'hD0 + i);
    end
    @(negedge clk);
    engBufWe = 1'b0;
    respond(8'h04, 8'h00);
    cpuRead(3'd5, 8'h04, "R7 block count");
    cpuRead(3'd2, 8'h14, "R5 control after block");
    for (int i = 0; i < 4; i++)
      cpuRead(3'd7, 8'(8'hD0 + i), "R10 engine-filled entry");

    repeat (3) @(negedge clk);
    chk(sbQ.size() == 0, "scoreboard drained", sbQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule